// File: doc/BRIEF.md
# Board Control and Slot-ID Register

This block sits on a simple local peripheral bus (chip select, address, read strobe, write strobe, 8-bit data). A single address carries two unrelated registers. A write to it lands in a write-only board control register. Four of its bits light the board status indicators, and its top bit asks for a board-wide reset. A read from that same address returns the backplane slot number. That number is strapped on five input pins, and each pin passes through a two-flop synchronizer first.

Software starts a reset by writing 1 to the top bit. The block then drives an active-low reset pulse of fixed length to the processor, the bus bridge and the line framers. The request bit is never stored, so it clears itself, and software never has to write 0 to it. Every access finishes in one cycle. There is no handshake and no back-pressure. Write data is captured at the clock edge where the strobe is seen, and read data is valid in the same cycle as the read strobe.

Top module: `brd_ctl_regs`

## Requirements
- R1: After power-on reset, led_on is 0000, brd_rst_n is 1, and bus_rdata is 0 when no read is addressed.
- R2: A write hit (bus_cs=1, bus_wr=1, bus_addr=BASE) loads bus_wdata[3:0] into led_on at the next clock edge. Bit 0 is the IOP lamp, bit 1 is ACT, bit 2 is STAT0 and bit 3 is STAT1, and 1 means lit.
- R3: bus_wdata bits 6..4 have no effect on led_on or on brd_rst_n.
- R4: With no write hit (chip select low, write low, or another address), led_on holds its value.
- R5: A read hit (bus_cs=1, bus_rd=1, bus_addr=BASE) returns {000, slot} in the same cycle. Here slot is the slot_pins value as it stood two clock edges earlier, a strapped-high pin reads 1, and the LED value is never returned.
- R6: bus_rdata is 0 in any cycle without a read hit.
- R7: Read accesses never change led_on.
- R8: A write hit with bus_wdata[7]=1 while brd_rst_n=1 drives brd_rst_n low from the next edge for exactly PULSE_LEN cycles (default 16).
- R9: A further reset request while brd_rst_n is low does not lengthen the pulse.
- R10: The reset request clears itself. Once the pulse ends, brd_rst_n stays high until a new write with bit 7 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_cs | input | 1 | Chip select |
| bus_addr | input | ADDR_W (4) | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, slot ID on a read hit, else 0 |
| slot_pins | input | 5 | Backplane slot strap pins (asynchronous) |
| led_on | output | 4 | Status lamp drives, 1 = lit |
| brd_rst_n | output | 1 | Stretched active-low board reset |

## Verification
The hardest case to reach is a reset request that arrives while a pulse is already running, because it must be ignored and must not restart the count. The bench writes bit 7 again a few cycles into a directed pulse. Its random mix also writes to the matching address often enough that requests keep landing inside pulses. Every completed low run is measured against PULSE_LEN. Slot pins are changed right before reads, which exposes the two-edge synchronizer delay.

// File: rtl/brd_ctl_pkg.sv
`timescale 1ns/1ps
package brd_ctl_pkg;
  localparam int DATA_W  = 8;
  localparam int LED_W   = 4;
  localparam int SLOT_W  = 5;
  localparam int RST_BIT = 7;
endpackage

// File: rtl/brd_ctl_sync.sv
`timescale 1ns/1ps
module brd_ctl_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/brd_ctl_pulse.sv
`timescale 1ns/1ps
module brd_ctl_pulse #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic pulse_n
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  // A running pulse ignores new requests; the request itself is never stored.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    else if (req)           cnt_q <= CW'(LEN);
  end

  assign pulse_n = (cnt_q == '0);
endmodule

// File: rtl/brd_ctl_regs.sv
`timescale 1ns/1ps
module brd_ctl_regs
  import brd_ctl_pkg::*;
#(
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] BASE    = '0,
  parameter int              PULSE_LEN = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cs,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SLOT_W-1:0] slot_pins,
  output logic [LED_W-1:0]  led_on,
  output logic              brd_rst_n
);
  logic              hit, wr_hit, rd_hit;
  logic [SLOT_W-1:0] slot_q;
  logic [LED_W-1:0]  led_q;
  logic              unused_bits;

  assign hit    = bus_cs && (bus_addr == BASE);
  assign wr_hit = hit && bus_wr;
  assign rd_hit = hit && bus_rd;
  assign unused_bits = ^bus_wdata[RST_BIT-1:LED_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      led_q <= '0;
    else if (wr_hit) led_q <= bus_wdata[LED_W-1:0];
  end
  assign led_on = led_q;

  brd_ctl_sync #(.W(SLOT_W), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (slot_pins),
    .q_sync  (slot_q)
  );

  brd_ctl_pulse #(.LEN(PULSE_LEN)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (wr_hit && bus_wdata[RST_BIT]),
    .pulse_n (brd_rst_n)
  );

  assign bus_rdata = rd_hit ? {{(DATA_W-SLOT_W){1'b0}}, slot_q} : '0;
endmodule

// File: rtl/brd_ctl_chk.sv
`timescale 1ns/1ps
module brd_ctl_chk #(
  parameter int              ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] BASE    = '0,
  parameter int              PULSE_LEN = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_cs,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic [3:0]        led_on,
  input logic              brd_rst_n
);
  logic c_wr, c_rd;
  int   low_run_q;

  assign c_wr = bus_cs && bus_wr && (bus_addr == BASE);
  assign c_rd = bus_cs && bus_rd && (bus_addr == BASE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run_q <= 0;
    else if (!brd_rst_n) low_run_q <= low_run_q + 1;
    else                 low_run_q <= 0;
  end

  // R2
  led_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    c_wr |=> led_on == $past(bus_wdata[3:0]));

  // R4
  led_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_wr |=> $stable(led_on));

  // R6
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !c_rd |-> bus_rdata == 8'h00);

  // R8
  rst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (c_wr && bus_wdata[7] && brd_rst_n) |=> !brd_rst_n);

  // R9
  rst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !brd_rst_n |-> low_run_q < PULSE_LEN);

  // R8
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brd_rst_n) |-> low_run_q == PULSE_LEN);
endmodule

bind brd_ctl_regs brd_ctl_chk #(.ADDR_W(ADDR_W), .BASE(BASE), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_cs    (bus_cs),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .led_on    (led_on),
  .brd_rst_n (brd_rst_n)
);

// File: tb/brd_ctl_regs_test.sv
`timescale 1ns/1ps
module brd_ctl_regs_test;
  localparam int PULSE = 16;
  localparam logic [3:0] BASE = 4'h0;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_cs = 1'b0;
  logic [3:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [4:0] slot_pins = 5'h00;
  logic [3:0] led_on;
  logic       brd_rst_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [3:0] m_led = '0;
  int         m_cnt = 0;
  logic [4:0] m_s1 = '0, m_s2 = '0;
  int         low_run = 0;

  always #2.5 clk = ~clk;

  brd_ctl_regs #(.ADDR_W(4), .BASE(BASE), .PULSE_LEN(PULSE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cs(bus_cs), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .slot_pins(slot_pins), .led_on(led_on),
    .brd_rst_n(brd_rst_n)
  );

  function automatic logic [7:0] exp_rdata(logic cs, logic [3:0] a, logic rd, logic [4:0] s);
    return (cs && rd && a == BASE) ? {3'b000, s} : 8'h00;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic cs, logic [3:0] a, logic wr, logic rd,
                      logic [7:0] wd, logic [4:0] pins, string ltag, string rtag);
    logic hit_wr;
    @(negedge clk);
    bus_cs = cs; bus_addr = a; bus_wr = wr; bus_rd = rd; bus_wdata = wd; slot_pins = pins;
    #1;
    check((cs && rd && a == BASE) ? "R5 slot read" : "R6 idle read",
          bus_rdata, exp_rdata(cs, a, rd, m_s2));
    hit_wr = cs && wr && (a == BASE);
    @(posedge clk);
    if (hit_wr) m_led = wd[3:0];
    if (m_cnt != 0) m_cnt--;
    else if (hit_wr && wd[7]) m_cnt = PULSE;
    m_s2 = m_s1; m_s1 = pins;
    #1;
    check(ltag, led_on, m_led);
    check(rtag, brd_rst_n, (m_cnt == 0));
    if (!brd_rst_n) low_run++;
    else if (low_run != 0) begin
      check("R9 pulse length", low_run, PULSE);
      low_run = 0;
    end
  endtask

  task automatic idle(int n, string rtag);
    for (int i = 0; i < n; i++) step(1'b0, 4'h0, 1'b0, 1'b0, 8'h00, slot_pins, "R4 idle hold", rtag);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1c0de5));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    check("R1 led reset", led_on, 0);
    check("R1 rst_n reset", brd_rst_n, 1);
    check("R1 rdata reset", bus_rdata, 0);
    rst_n = 1'b1;

    // R2 load LEDs, individual patterns
    step(1, BASE, 1, 0, 8'h0F, 5'h00, "R2 led write", "R8 no pulse");
    step(1, BASE, 1, 0, 8'h05, 5'h00, "R2 led write", "R8 no pulse");
    // R3 bits 6..4 ignored
    step(1, BASE, 1, 0, 8'h70, 5'h00, "R3 ignored bits", "R3 no pulse");
    // R4 miss: other address, no cs
    step(1, 4'h3, 1, 0, 8'h0A, 5'h00, "R4 addr miss", "R8 no pulse");
    step(0, BASE, 1, 0, 8'h8A, 5'h00, "R4 cs miss", "R8 no pulse");
    // R5 synchronizer delay: pins change, reads before and after
    step(1, BASE, 0, 1, 8'h00, 5'h15, "R7 read no led", "R8 no pulse");
    step(1, BASE, 0, 1, 8'h00, 5'h15, "R7 read no led", "R8 no pulse");
    step(1, BASE, 0, 1, 8'h00, 5'h1F, "R7 read no led", "R8 no pulse");
    step(1, 4'h1, 0, 1, 8'h00, 5'h1F, "R7 read no led", "R8 no pulse");
    // R8 reset pulse, R9 re-request mid-pulse
    step(1, BASE, 1, 0, 8'h83, 5'h1F, "R2 led write", "R8 pulse start");
    idle(4, "R8 pulse");
    step(1, BASE, 1, 0, 8'h8C, 5'h1F, "R2 led write", "R9 no extend");
    idle(PULSE, "R9 pulse end");
    // R10 self-clear: stays high, non-reset write keeps it high
    idle(10, "R10 stays high");
    step(1, BASE, 1, 0, 8'h7F, 5'h1F, "R2 led write", "R10 no request");
    idle(3, "R10 stays high");

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      logic cs, wr, rd;
      logic [3:0] a;
      logic [7:0] wd;
      cs = ($urandom % 4) != 0;
      a  = (($urandom % 3) != 0) ? BASE : 4'($urandom);
      wr = ($urandom % 3) == 0;
      rd = ($urandom % 2) == 0;
      wd = 8'($urandom);
      if (($urandom % 4) != 0) wd[7] = 1'b0;
      step(cs, a, wr, rd, wd, 5'($urandom), wr ? "R2 random write" : "R4 random hold",
           "R8 random pulse");
    end
    idle(PULSE + 2, "R10 drain");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule